// File: doc/BRIEF.md
# Random Number Generator Peripheral Controller

This block is the digital side of a memory-mapped random number generator. A noise source outside the block delivers one bit at a time on `noise_bit`, each qualified by a `noise_vld` strobe. The block shifts these bits into 32-bit words and gathers them into a four-entry output buffer. When the buffer holds four fresh words it raises data-ready. Software then drains the buffer with four back-to-back reads of the data register.

The block also monitors the health of the noise source. A long run of identical noise bits is reported as a seed error. A long gap between strobes is reported as a clock error, and this check can be turned off. Both error indications stay latched until software clears them.

A conditional reset lets software restart the generation path without a system reset. Software sets the reset bit in the control register and then clears it. The control register keeps reporting the bit as 1 until the internal flush has finished.

Top module: `rng_ctrl`

## Requirements
- R1: Registers decode on the full address: control at 0x0 (bit 2 = generator enable, bit 5 = clock-check disable, bit 30 = conditional reset), status at 0x4, data at 0x8. All other control bits and every unmapped address read as 0.
- R2: Status bit 0 (data ready) and the `data_ready` port rise only after four complete 32-bit words have been assembled. Each word is filled first-bit-first, so the earliest bit lands in bit 31. With three words assembled, ready is still 0.
- R3: Once ready, four consecutive data reads return the four words in the order they were assembled. Words completed while ready is high are dropped.
- R4: After the fourth read, ready returns to 0. A data read while ready is 0 returns 0 and consumes nothing, and the next batch of four words makes the block ready again.
- R5: 64 consecutive valid noise bits of the same value set status bit 2 (seed error now) and status bit 6 (seed error flag). A run of 63 equal bits sets neither.
- R6: Status bit 2 falls as soon as a valid noise bit differs from the previous one. Status bit 6 stays set until software writes 0 to it. Writing 1 to a status flag bit leaves that flag unchanged.
- R7: While the generator is enabled, 1024 clock cycles without a noise strobe set status bit 5 (clock error flag). No flag is raised while control bit 5 is 1.
- R8: A conditional reset empties the buffer, clears ready and throws away any partially assembled word.
- R9: Control bit 30 reads 1 while it is set, and for exactly 8 cycles after software writes it back to 0. After that it reads 0.
- R10: With the enable bit at 0, which is the case after control is written to 0, no words are assembled and no clock error is raised.
- R11: Recovery sequence: software clears status bit 6 and then makes twelve data reads. If the noise has started toggling again, bit 6 is still 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a data read pops one word |
| bus_rdata | output | 32 | Read data (combinational from address) |
| noise_bit | input | 1 | Serial noise bit |
| noise_vld | input | 1 | Qualifies noise_bit for one cycle |
| data_ready | output | 1 | Four words are waiting in the buffer |

## Verification
The hardest case to reach is a seed error that crosses the 64-bit threshold by exactly one bit. The run counter carries over between words, and it is cleared only by a toggle or a conditional reset.

To control this, the bench first issues a conditional reset so the counter starts from zero. It then sends one 1-bit followed by exactly 63 zeros and checks that no error is raised. A single further zero must then raise both indications.

A second delicate case is the exact 8-cycle tail of the reset bit. The bench holds a control read open and samples it at each falling edge after the clearing write.

// File: rtl/rng_pkg.sv
package rng_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned OFF_CTRL = 'h0;
    localparam int unsigned OFF_STAT = 'h4;
    localparam int unsigned OFF_DATA = 'h8;
    // control bit positions
    localparam int unsigned CTL_EN   = 2;
    localparam int unsigned CTL_CED  = 5;
    localparam int unsigned CTL_CRST = 30;
    // status bit positions
    localparam int unsigned ST_RDY   = 0;
    localparam int unsigned ST_SCUR  = 2;
    localparam int unsigned ST_CFLG  = 5;
    localparam int unsigned ST_SFLG  = 6;
endpackage

// File: rtl/rng_assemble.sv
module rng_assemble #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         noise_bit,
    input  logic         noise_vld,
    output logic         word_vld,
    output logic [W-1:0] word
);
    localparam int unsigned CNT_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [W-1:0]     word;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (clr) begin
            s_d = '0;
        end else if (en && noise_vld) begin
            s_d.sh = {s_q.sh[W-2:0], noise_bit};
            if (s_q.cnt == CNT_W'(W-1)) begin
                s_d.vld  = 1'b1;
                s_d.word = {s_q.sh[W-2:0], noise_bit};
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_vld = s_q.vld;
    assign word     = s_q.word;

    // R8: a clear leaves no word pending
    a_r8_clr_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !word_vld);
endmodule

// File: rtl/rng_health.sv
module rng_health #(
    parameter int unsigned LIMIT   = 64,
    parameter int unsigned TIMEOUT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic ced,
    input  logic noise_bit,
    input  logic noise_vld,
    output logic seed_cur,
    output logic seed_hit,
    output logic clk_hit
);
    localparam int unsigned RUN_W = $clog2(LIMIT + 1);
    localparam int unsigned TMO_W = $clog2(TIMEOUT);

    typedef struct packed {
        logic             last;
        logic [RUN_W-1:0] run;
        logic [TMO_W-1:0] tmo;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        seed_hit = 1'b0;
        clk_hit  = 1'b0;
        if (clr) begin
            s_d = '0;
        end else begin
            if (en && noise_vld) begin
                s_d.last = noise_bit;
                if (s_q.run != '0 && noise_bit == s_q.last) begin
                    if (s_q.run != RUN_W'(LIMIT)) s_d.run = s_q.run + 1'b1;
                    if (s_q.run == RUN_W'(LIMIT - 1)) seed_hit = 1'b1;
                end else begin
                    s_d.run = RUN_W'(1);
                end
            end
            if (en && !ced && !noise_vld) begin
                if (s_q.tmo == TMO_W'(TIMEOUT - 1)) begin
                    clk_hit = 1'b1;
                    s_d.tmo = '0;
                end else begin
                    s_d.tmo = s_q.tmo + 1'b1;
                end
            end else begin
                s_d.tmo = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign seed_cur = (s_q.run == RUN_W'(LIMIT));

    a_r5_hit_sets_state: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_hit && !clr) |=> seed_cur);

    a_r6_toggle_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_cur && en && noise_vld && !clr && noise_bit != s_q.last) |=> !seed_cur);
endmodule

// File: rtl/rng_outbuf.sv
module rng_outbuf #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_word,
    input  logic         pop,
    output logic         ready,
    output logic [W-1:0] head
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        count;
        logic                    ready;
    } st_t;

    st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.wp    = '0;
            s_d.rp    = '0;
            s_d.count = '0;
            s_d.ready = 1'b0;
        end else if (!s_q.ready) begin
            if (push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (s_q.wp == PTR_W'(i)) s_d.mem[i] = push_word;
                end
                s_d.wp    = nxt(s_q.wp);
                s_d.count = s_q.count + 1'b1;
                if (s_q.count == CNT_W'(DEPTH - 1)) s_d.ready = 1'b1;
            end
        end else if (pop) begin
            s_d.rp    = nxt(s_q.rp);
            s_d.count = s_q.count - 1'b1;
            if (s_q.count == CNT_W'(1)) s_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ready = s_q.ready;
    assign head  = s_q.ready ? s_q.mem[s_q.rp] : '0;

    a_r2_ready_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ready |-> (s_q.count != '0));

    a_r3_full_ignores_push: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ready && !pop && !clr) |=> (s_q.count == $past(s_q.count)));
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned BUF_DEPTH   = 4,
    parameter int unsigned STUCK_LIMIT = 64,
    parameter int unsigned CLK_TIMEOUT = 1024,
    parameter int unsigned CRST_HOLD   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              noise_bit,
    input  logic              noise_vld,
    output logic              data_ready
);
    import rng_pkg::*;

    localparam int unsigned HOLD_W = $clog2(CRST_HOLD + 1);

    typedef struct packed {
        logic              en;
        logic              ced;
        logic              crst;
        logic [HOLD_W-1:0] hold;
        logic              sflag;
        logic              cflag;
    } st_t;

    st_t s_d, s_q;

    logic             clr, seed_cur, seed_hit, clk_hit;
    logic             word_vld, buf_ready, pop;
    logic [REG_W-1:0] word, head;
    logic             sel_ctrl, sel_stat, sel_data;
    logic             unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
    assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
    assign clr      = s_q.crst || (s_q.hold != '0);
    assign pop      = bus_rd && sel_data && !clr;

    rng_assemble #(.W(REG_W)) u_asm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(s_q.en),
        .noise_bit(noise_bit), .noise_vld(noise_vld),
        .word_vld(word_vld), .word(word)
    );

    rng_health #(.LIMIT(STUCK_LIMIT), .TIMEOUT(CLK_TIMEOUT)) u_hlth (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(s_q.en), .ced(s_q.ced),
        .noise_bit(noise_bit), .noise_vld(noise_vld),
        .seed_cur(seed_cur), .seed_hit(seed_hit), .clk_hit(clk_hit)
    );

    rng_outbuf #(.W(REG_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(word_vld),
        .push_word(word), .pop(pop), .ready(buf_ready), .head(head)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.hold != '0) s_d.hold = s_q.hold - 1'b1;
        if (bus_wr && sel_ctrl) begin
            s_d.en   = bus_wdata[CTL_EN];
            s_d.ced  = bus_wdata[CTL_CED];
            s_d.crst = bus_wdata[CTL_CRST];
            if (s_q.crst && !bus_wdata[CTL_CRST]) s_d.hold = HOLD_W'(CRST_HOLD);
        end
        if (bus_wr && sel_stat) begin
            s_d.sflag = s_q.sflag & bus_wdata[ST_SFLG];
            s_d.cflag = s_q.cflag & bus_wdata[ST_CFLG];
        end
        if (seed_hit) s_d.sflag = 1'b1;
        if (clk_hit)  s_d.cflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[CTL_EN]   = s_q.en;
            bus_rdata[CTL_CED]  = s_q.ced;
            bus_rdata[CTL_CRST] = clr;
        end else if (sel_stat) begin
            bus_rdata[ST_RDY]  = buf_ready;
            bus_rdata[ST_SCUR] = seed_cur;
            bus_rdata[ST_CFLG] = s_q.cflag;
            bus_rdata[ST_SFLG] = s_q.sflag;
        end else if (sel_data) begin
            bus_rdata = head;
        end
    end

    assign data_ready = buf_ready;

    a_r8_reset_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !buf_ready);

    a_r7_ced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ced |-> !clk_hit);

    a_r5_flag_latches: assert property (@(posedge clk) disable iff (!rst_n)
        seed_hit |=> s_q.sflag);

    a_r9_hold_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold != '0 && !s_q.crst) |=> (s_q.hold == HOLD_W'($past(s_q.hold) - 1'b1)));
endmodule

// File: tb/sim_rng_ctrl.sv
module sim_rng_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        noise_bit = 1'b0;
    logic        noise_vld = 1'b0;
    logic        data_ready;

    int checks = 0;
    int errors = 0;

    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_DATA = 4'h8;
    localparam logic [31:0] EN = 32'h4, CED = 32'h20, CRST = 32'h4000_0000;

    always #5 clk = ~clk;

    rng_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .noise_bit(noise_bit), .noise_vld(noise_vld), .data_ready(data_ready)
    );

    function automatic logic [31:0] wk(input int k);
        return (32'h9E37_79B9 * (k + 1)) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_w(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_r(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            noise_vld = 1'b1; noise_bit = v[i];
        end
        @(negedge clk);
        noise_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cond_reset();
        bus_w(A_CTRL, CRST | EN | CED);
        bus_w(A_CTRL, EN | CED);
        idle(12);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        bus_r(A_CTRL, r); chk("R1 ctrl reset", r, 32'h0);
        bus_r(A_STAT, r); chk("R1 stat reset", r, 32'h0);
        bus_r(A_DATA, r); chk("R4 data reset", r, 32'h0);
        bus_r(4'hC, r);   chk("R1 unmapped", r, 32'h0);
        chk("R2 port reset", {31'b0, data_ready}, 32'h0);
    endtask

    task automatic t_fill();
        logic [31:0] r;
        bus_w(A_CTRL, 32'hFFFF_FFFF & ~CRST);
        bus_r(A_CTRL, r); chk("R1 ctrl readback", r, EN | CED);
        for (int k = 0; k < 3; k++) send_bits(wk(k), 32);
        idle(4);
        bus_r(A_STAT, r); chk("R2 three words not ready", r & 32'h1, 32'h0);
        send_bits(wk(3), 32);
        idle(4);
        bus_r(A_STAT, r); chk("R2 four words ready", r & 32'h1, 32'h1);
        chk("R2 port ready", {31'b0, data_ready}, 32'h1);
        send_bits(wk(4), 32);
        idle(4);
        for (int k = 0; k < 4; k++) begin
            bus_r(A_DATA, r); chk("R3 burst word", r, wk(k));
        end
        bus_r(A_STAT, r); chk("R4 drained not ready", r & 32'h1, 32'h0);
        bus_r(A_DATA, r); chk("R4 empty read zero", r, 32'h0);
        for (int k = 5; k < 9; k++) send_bits(wk(k), 32);
        idle(4);
        bus_r(A_STAT, r); chk("R4 refill ready", r & 32'h1, 32'h1);
        bus_r(A_DATA, r); chk("R3 dropped word absent", r, wk(5));
        for (int k = 6; k < 9; k++) begin
            bus_r(A_DATA, r); chk("R3 refill word", r, wk(k));
        end
    endtask

    task automatic t_seed();
        logic [31:0] r;
        cond_reset();
        bus_w(A_STAT, 32'h0);
        send_bits(32'h1, 1);
        send_bits(32'h0, 32);
        send_bits(32'h0, 31);
        bus_r(A_STAT, r); chk("R5 run 63 no error", r & 32'h44, 32'h0);
        send_bits(32'h0, 1);
        bus_r(A_STAT, r); chk("R5 run 64 error", r & 32'h44, 32'h44);
        send_bits(32'h1, 1);
        bus_r(A_STAT, r); chk("R6 toggle drops state", r & 32'h44, 32'h40);
        bus_w(A_STAT, 32'hFFFF_FFFF);
        bus_r(A_STAT, r); chk("R6 write one keeps flag", r & 32'h40, 32'h40);
        send_bits(32'h5, 3);
        bus_w(A_STAT, 32'hFFFF_FFBF);
        for (int i = 0; i < 12; i++) bus_r(A_DATA, r);
        bus_r(A_STAT, r); chk("R11 recovered flag clear", r & 32'h44, 32'h0);
    endtask

    task automatic t_clock();
        logic [31:0] r;
        cond_reset();
        bus_w(A_STAT, 32'h0);
        bus_w(A_CTRL, EN);
        idle(1000);
        bus_r(A_STAT, r); chk("R7 before timeout", r & 32'h20, 32'h0);
        idle(40);
        bus_r(A_STAT, r); chk("R7 after timeout", r & 32'h20, 32'h20);
        bus_w(A_STAT, 32'h0);
        bus_w(A_CTRL, EN | CED);
        idle(1100);
        bus_r(A_STAT, r); chk("R7 disabled check quiet", r & 32'h20, 32'h0);
        bus_w(A_CTRL, 32'h0);
        bus_r(A_CTRL, r); chk("R10 ctrl zero", r, 32'h0);
        idle(1100);
        for (int k = 0; k < 4; k++) send_bits(wk(k), 32);
        idle(4);
        bus_r(A_STAT, r); chk("R10 off no words no clk err", r & 32'h21, 32'h0);
    endtask

    task automatic t_crst();
        logic [31:0] r;
        bus_w(A_CTRL, EN | CED);
        for (int k = 0; k < 4; k++) send_bits(wk(k), 32);
        send_bits(32'hABCD_0000, 16);
        idle(4);
        bus_r(A_STAT, r); chk("R8 ready before reset", r & 32'h1, 32'h1);
        bus_w(A_CTRL, CRST | EN | CED);
        bus_r(A_CTRL, r); chk("R9 bit set reads one", r, CRST | EN | CED);
        bus_w(A_CTRL, EN | CED);
        bus_addr = A_CTRL; bus_rd = 1'b1;
        #1 chk("R9 first hold cycle", bus_rdata & CRST, CRST);
        repeat (7) @(negedge clk);
        #1 chk("R9 eighth hold cycle", bus_rdata & CRST, CRST);
        @(negedge clk);
        #1 chk("R9 released", bus_rdata & CRST, 32'h0);
        bus_rd = 1'b0;
        bus_r(A_STAT, r); chk("R8 flushed not ready", r & 32'h1, 32'h0);
        bus_r(A_DATA, r); chk("R8 flushed data zero", r, 32'h0);
        for (int k = 9; k < 13; k++) send_bits(wk(k), 32);
        idle(4);
        bus_r(A_DATA, r); chk("R8 partial word dropped", r, wk(9));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_seed();
        t_clock();
        t_crst();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule